// File: doc/BRIEF.md
# Dual-Port Flash Access Arbiter

Two requesting ports share a set of flash arrays. Each array has its own command interface. A port presents one access at a time, made of a valid flag, an access class (write, read or prefetch), an array index, an address, a size code and write data. It keeps that request steady until the block reports that the access is complete. The block decides which port drives each array. It drives that array's read enable, write enable, address, size and write data from registers. It then waits for the array's completion strobe and hands the array's response word back to the port that owns the access.

Arbitration happens only when both ports target the same array in the same idle cycle. The access class settles it first. When the classes are equal, a 2-bit mode input breaks the tie: port 0 first, port 1 first, or alternating. Requests that target different arrays are each granted at once on their own array. Each array carries at most one access at a time. The array is treated as a fixed-latency handshake that ends with a one-cycle completion strobe.

Top module: `flash_dual_arbiter`

## Requirements
- R1: Access class is encoded as 00 prefetch, 01 read, 1x write. When both ports contend for one array, a write beats a read or a prefetch, and a read beats a prefetch, whichever port issues it and whatever the mode.
- R2: With mode 00, a same-class contention is won by port 0.
- R3: With mode 01, a same-class contention is won by port 1.
- R4: With mode 1x, a same-class contention is won by the favoured port of that array. Port 0 is favoured after reset. The favour moves to the loser only when a same-class contention is resolved; single requests and class-decided contentions leave it unchanged.
- R5: Requests to different arrays (array index on req_sel_i) are granted in the same cycle with no arbitration, and both complete together when the arrays have equal latency.
- R6: While an access is in flight, the array sees the granted port's address, size and write data. It sees the write enable for a write, or the read enable for a read or prefetch, never both.
- R7: done_o[p] and a non-zero rdata_o[p] appear only in the cycle in which the array completes an access owned by port p. rdata_o[p] then equals that array's response word.
- R8: An array carries one access at a time. The losing port waits with no grant. After a completion the array's enables are low for at least one cycle before the next grant.
- R9: After reset all array enables, gnt_o and done_o are low.
- R10: A completion strobe from an array with no access in flight has no effect: no done_o, and later accesses are unaffected.
- R11: A request seen by an idle array raises the array enable and gnt_o of that port in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Same-class tie-break: 00 port 0, 01 port 1, 1x alternating |
| req_valid_i | input | 2 | Request valid per port |
| req_type_i | input | 2x2 | Access class per port |
| req_sel_i | input | 2xSELW | Target array per port |
| req_addr_i | input | 2xAW | Array address per port |
| req_size_i | input | 2xSW | Write size code per port |
| req_wdata_i | input | 2xDW | Write data per port |
| gnt_o | output | 2 | Port owns an access in flight |
| done_o | output | 2 | Access of this port completes this cycle |
| rdata_o | output | 2xDW | Array response word, valid with done_o |
| arr_rd_en_o | output | NARR | Read enable per array |
| arr_wr_en_o | output | NARR | Write enable per array |
| arr_addr_o | output | NARRxAW | Address per array |
| arr_size_o | output | NARRxSW | Size code per array |
| arr_wdata_o | output | NARRxDW | Write data per array |
| arr_ack_i | input | NARR | Completion strobe per array |
| arr_rdata_i | input | NARRxDW | Response word per array |

## Verification
Simultaneous same-class requests are tried under each mode. They show whether the tie-break follows the mode input and not a fixed port order. Mixed-class pairs, a write against a read and a read against a prefetch, are placed so that the class winner is the port the mode would lose. This separates class priority from port priority. In alternating mode, a same-class conflict, then a second one, then a class-decided conflict, then another same-class conflict show whether the favour moves only on real ties. Requests to two arrays at once, and a stray completion strobe on an idle array, test independence between arrays and immunity to spurious strobes.

// File: rtl/farb_pkg.sv
package farb_pkg;
  localparam int NP = 2;

  typedef enum logic [1:0] {
    ACC_PREF  = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10
  } acc_e;

  function automatic logic [1:0] acc_rank(input logic [1:0] t);
    return t[1] ? 2'd2 : (t[0] ? 2'd1 : 2'd0);
  endfunction
endpackage

// File: rtl/farb_pick.sv
module farb_pick
  import farb_pkg::*;
(
  input  logic [NP-1:0] cand_i,
  input  logic [1:0]    type0_i,
  input  logic [1:0]    type1_i,
  input  logic [1:0]    mode_i,
  input  logic          rr_fav_i,
  output logic          win_vld_o,
  output logic          win_o,
  output logic          rr_tie_o
);
  logic [1:0] rk0, rk1;
  logic       both;

  assign rk0  = acc_rank(type0_i);
  assign rk1  = acc_rank(type1_i);
  assign both = &cand_i;

  always_comb begin
    win_vld_o = |cand_i;
    rr_tie_o  = 1'b0;
    if (!both)           win_o = cand_i[1];
    else if (rk0 > rk1)  win_o = 1'b0;
    else if (rk1 > rk0)  win_o = 1'b1;
    else if (mode_i[1]) begin
      win_o    = rr_fav_i;
      rr_tie_o = 1'b1;
    end
    else                 win_o = mode_i[0];
  end
endmodule

// File: rtl/farb_arr_ctrl.sv
module farb_arr_ctrl
  import farb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int SW = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             mode_i,
  input  logic [NP-1:0]          cand_i,
  input  logic [NP-1:0][1:0]     type_i,
  input  logic [NP-1:0][AW-1:0]  addr_i,
  input  logic [NP-1:0][SW-1:0]  size_i,
  input  logic [NP-1:0][DW-1:0]  wdata_i,
  input  logic                   ack_i,
  output logic                   rd_en_o,
  output logic                   wr_en_o,
  output logic [AW-1:0]          addr_o,
  output logic [SW-1:0]          size_o,
  output logic [DW-1:0]          wdata_o,
  output logic                   busy_o,
  output logic                   owner_o
);
  logic          busy_q, owner_q, wr_q, rr_q;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] size_q;
  logic [DW-1:0] wdata_q;
  logic          win_vld, win, rr_tie;

  farb_pick u_pick (
    .cand_i   (cand_i),
    .type0_i  (type_i[0]),
    .type1_i  (type_i[1]),
    .mode_i   (mode_i),
    .rr_fav_i (rr_q),
    .win_vld_o(win_vld),
    .win_o    (win),
    .rr_tie_o (rr_tie)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      owner_q <= 1'b0;
      wr_q    <= 1'b0;
      rr_q    <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
    end else if (busy_q) begin
      if (ack_i) busy_q <= 1'b0;
    end else if (win_vld) begin
      busy_q  <= 1'b1;
      owner_q <= win;
      wr_q    <= type_i[win][1];
      addr_q  <= addr_i[win];
      size_q  <= size_i[win];
      wdata_q <= wdata_i[win];
      if (rr_tie) rr_q <= ~win;
    end
  end

  assign rd_en_o = busy_q & ~wr_q;
  assign wr_en_o = busy_q &  wr_q;
  assign addr_o  = addr_q;
  assign size_o  = size_q;
  assign wdata_o = wdata_q;
  assign busy_o  = busy_q;
  assign owner_o = owner_q;

  p_en_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_en_o, wr_en_o}));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ack_i) |=> (busy_q && $stable(owner_q) && $stable(addr_q)));
  p_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ack_i) |=> !(rd_en_o || wr_en_o));
  p_write_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && &cand_i && type_i[0][1] && !type_i[1][1]) |=> (busy_q && !owner_q));
  p_fixed_p0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && &cand_i && mode_i == 2'b00 && acc_rank(type_i[0]) == acc_rank(type_i[1]))
    |=> !owner_q);
  p_fixed_p1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && &cand_i && mode_i == 2'b01 && acc_rank(type_i[0]) == acc_rank(type_i[1]))
    |=> owner_q);
  p_rr_fav_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && &cand_i && mode_i[1] && acc_rank(type_i[0]) == acc_rank(type_i[1]))
    |=> (owner_q == $past(rr_q) && rr_q != $past(rr_q)));
  p_stray_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && ack_i && !(|cand_i)) |=> !busy_q);
endmodule

// File: rtl/farb_port_ret.sv
module farb_port_ret #(
  parameter int NARR = 2,
  parameter int DW   = 32,
  parameter bit PIDX = 1'b0
) (
  input  logic [NARR-1:0]         busy_i,
  input  logic [NARR-1:0]         owner_i,
  input  logic [NARR-1:0]         ack_i,
  input  logic [NARR-1:0][DW-1:0] rdata_i,
  output logic                    gnt_o,
  output logic                    done_o,
  output logic [DW-1:0]           rdata_o
);
  logic [NARR-1:0]         own, fin;
  logic [NARR-1:0][DW-1:0] masked;

  for (genvar a = 0; a < NARR; a++) begin : g_arr
    assign own[a]    = busy_i[a] & (owner_i[a] == PIDX);
    assign fin[a]    = own[a] & ack_i[a];
    assign masked[a] = fin[a] ? rdata_i[a] : '0;
  end

  always_comb begin
    rdata_o = '0;
    for (int a = 0; a < NARR; a++) rdata_o |= masked[a];
  end

  assign gnt_o  = |own;
  assign done_o = |fin;
endmodule

// File: rtl/flash_dual_arbiter.sv
module flash_dual_arbiter
  import farb_pkg::*;
#(
  parameter int NARR = 2,
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int SW   = 2,
  localparam int SELW = (NARR > 1) ? $clog2(NARR) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               mode_i,
  input  logic [NP-1:0]            req_valid_i,
  input  logic [NP-1:0][1:0]       req_type_i,
  input  logic [NP-1:0][SELW-1:0]  req_sel_i,
  input  logic [NP-1:0][AW-1:0]    req_addr_i,
  input  logic [NP-1:0][SW-1:0]    req_size_i,
  input  logic [NP-1:0][DW-1:0]    req_wdata_i,
  output logic [NP-1:0]            gnt_o,
  output logic [NP-1:0]            done_o,
  output logic [NP-1:0][DW-1:0]    rdata_o,
  output logic [NARR-1:0]          arr_rd_en_o,
  output logic [NARR-1:0]          arr_wr_en_o,
  output logic [NARR-1:0][AW-1:0]  arr_addr_o,
  output logic [NARR-1:0][SW-1:0]  arr_size_o,
  output logic [NARR-1:0][DW-1:0]  arr_wdata_o,
  input  logic [NARR-1:0]          arr_ack_i,
  input  logic [NARR-1:0][DW-1:0]  arr_rdata_i
);
  logic [NARR-1:0] busy, owner;

  for (genvar a = 0; a < NARR; a++) begin : g_arr
    logic [NP-1:0] cand;
    for (genvar p = 0; p < NP; p++) begin : g_cand
      assign cand[p] = req_valid_i[p] & (req_sel_i[p] == SELW'(a));
    end

    farb_arr_ctrl #(.AW(AW), .DW(DW), .SW(SW)) u_ctrl (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode_i),
      .cand_i (cand),
      .type_i (req_type_i),
      .addr_i (req_addr_i),
      .size_i (req_size_i),
      .wdata_i(req_wdata_i),
      .ack_i  (arr_ack_i[a]),
      .rd_en_o(arr_rd_en_o[a]),
      .wr_en_o(arr_wr_en_o[a]),
      .addr_o (arr_addr_o[a]),
      .size_o (arr_size_o[a]),
      .wdata_o(arr_wdata_o[a]),
      .busy_o (busy[a]),
      .owner_o(owner[a])
    );
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    farb_port_ret #(.NARR(NARR), .DW(DW), .PIDX(p[0])) u_ret (
      .busy_i (busy),
      .owner_i(owner),
      .ack_i  (arr_ack_i),
      .rdata_i(arr_rdata_i),
      .gnt_o  (gnt_o[p]),
      .done_o (done_o[p]),
      .rdata_o(rdata_o[p])
    );

    p_done_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[p] |-> (req_valid_i[p] && gnt_o[p]));
    p_quiet_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o[p] |-> (rdata_o[p] == '0));
  end

  p_reset_quiet_r9: assert property (@(posedge clk_i)
    !rst_ni |-> !(|{arr_rd_en_o, arr_wr_en_o}));
endmodule

// File: tb/sim_flash_dual_arbiter.sv
module sim_flash_dual_arbiter;
  localparam int NARR = 2;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SW = 2;
  localparam int LAT = 3;

  typedef struct {
    int          port;
    logic [31:0] data;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]                 mode;
  logic [1:0]                 req_v;
  logic [1:0][1:0]            req_t;
  logic [1:0][0:0]            req_s;
  logic [1:0][AW-1:0]         req_a;
  logic [1:0][SW-1:0]         req_z;
  logic [1:0][DW-1:0]         req_w;
  logic [1:0]                 gnt, done;
  logic [1:0][DW-1:0]         rdata;
  logic [NARR-1:0]            rd_en, wr_en, ack, mack, stray;
  logic [NARR-1:0][AW-1:0]    a_addr;
  logic [NARR-1:0][SW-1:0]    a_size;
  logic [NARR-1:0][DW-1:0]    a_wdata, mrd;
  int                         mcnt [NARR];

  assign ack = mack | stray;

  flash_dual_arbiter #(.NARR(NARR), .AW(AW), .DW(DW), .SW(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .req_valid_i(req_v), .req_type_i(req_t), .req_sel_i(req_s),
    .req_addr_i(req_a), .req_size_i(req_z), .req_wdata_i(req_w),
    .gnt_o(gnt), .done_o(done), .rdata_o(rdata),
    .arr_rd_en_o(rd_en), .arr_wr_en_o(wr_en), .arr_addr_o(a_addr),
    .arr_size_o(a_size), .arr_wdata_o(a_wdata),
    .arr_ack_i(ack), .arr_rdata_i(mrd)
  );

  function automatic logic [31:0] resp(input logic wr, input int a, input logic [15:0] ad,
                                       input logic [1:0] sz, input logic [31:0] wd);
    return {wr ? 4'hC : 4'h5, 4'(a), 6'd0, sz, wr ? (ad ^ wd[15:0]) : ad};
  endfunction

  // Array model: one-cycle ack in the LAT-th enabled cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mack <= '0;
      mrd  <= '0;
      for (int a = 0; a < NARR; a++) mcnt[a] <= 0;
    end else begin
      for (int a = 0; a < NARR; a++) begin
        if (mack[a]) begin
          mack[a] <= 1'b0;
          mrd[a]  <= '0;
          mcnt[a] <= 0;
        end else if (rd_en[a] || wr_en[a]) begin
          if (mcnt[a] == LAT - 2) begin
            mack[a] <= 1'b1;
            mrd[a]  <= resp(wr_en[a], a, a_addr[a], a_size[a], a_wdata[a]);
          end
          mcnt[a] <= mcnt[a] + 1;
        end
      end
    end
  end

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int done_cyc [2];
  int mon_fail = 0;
  logic [NARR-1:0] prev_ack = '0;
  item_t exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Monitor: scoreboard compare plus per-cycle R7/R8 rules
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < 2; p++) begin
        if (done[p]) begin
          done_cyc[p] = cyc;
          if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected done", p, 0);
          end else begin
            item_t it;
            it = exp_q.pop_front();
            check(it.port == p, "R1-order port", p, it.port);
            check(rdata[p] == it.data, "R6 response word", rdata[p], it.data);
          end
        end else if (rdata[p] != '0) begin
          mon_fail++;
          $display("FAIL R7 rdata without done port=%0d actual=%0h expected=0", p, rdata[p]);
        end
      end
      for (int a = 0; a < NARR; a++) begin
        if (prev_ack[a] && (rd_en[a] || wr_en[a])) begin
          mon_fail++;
          $display("FAIL R8 no idle gap array=%0d actual=1 expected=0", a);
        end
        if (rd_en[a] && wr_en[a]) begin
          mon_fail++;
          $display("FAIL R6 both enables array=%0d actual=1 expected=0", a);
        end
      end
      prev_ack = ack;
    end
  end

  task automatic expect_item(input int p, input logic [1:0] t, input int a,
                             input logic [15:0] ad, input logic [1:0] sz, input logic [31:0] wd);
    item_t it;
    it.port = p;
    it.data = resp(t[1], a, ad, sz, wd);
    exp_q.push_back(it);
  endtask

  task automatic access(input int p, input logic [1:0] t, input int a,
                        input logic [15:0] ad, input logic [1:0] sz, input logic [31:0] wd);
    req_t[p] = t;
    req_s[p] = a[0];
    req_a[p] = ad;
    req_z[p] = sz;
    req_w[p] = wd;
    req_v[p] = 1'b1;
    do @(negedge clk); while (!done[p]);
    @(posedge clk);
    #1 req_v[p] = 1'b0;
  endtask

  // Both ports issue together; expected completion order given by first
  task automatic pair(input int first,
                      input logic [1:0] t0, input int a0, input logic [15:0] ad0,
                      input logic [1:0] t1, input int a1, input logic [15:0] ad1);
    @(posedge clk);
    #1;
    if (first == 0) begin
      expect_item(0, t0, a0, ad0, 2'd1, 32'h0000_1111);
      expect_item(1, t1, a1, ad1, 2'd2, 32'h0000_2222);
    end else begin
      expect_item(1, t1, a1, ad1, 2'd2, 32'h0000_2222);
      expect_item(0, t0, a0, ad0, 2'd1, 32'h0000_1111);
    end
    fork
      access(0, t0, a0, ad0, 2'd1, 32'h0000_1111);
      access(1, t1, a1, ad1, 2'd2, 32'h0000_2222);
    join
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    mode = 2'b00;
    req_v = '0; req_t = '0; req_s = '0; req_a = '0; req_z = '0; req_w = '0;
    stray = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({rd_en, wr_en, gnt, done} == '0, "R9 quiet in reset", {rd_en, wr_en, gnt, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({rd_en, wr_en, gnt, done} == '0, "R9 quiet after reset", {rd_en, wr_en, gnt, done}, 0);

    // R11: grant latency of one cycle from an idle array
    @(posedge clk);
    #1;
    expect_item(0, 2'b01, 0, 16'h0A10, 2'd3, 32'h0);
    req_t[0] = 2'b01; req_s[0] = 1'b0; req_a[0] = 16'h0A10; req_z[0] = 2'd3; req_w[0] = '0;
    req_v[0] = 1'b1;
    @(negedge clk);
    check(rd_en[0] == 1'b0, "R11 no enable in request cycle", rd_en[0], 0);
    @(negedge clk);
    check(rd_en[0] && gnt[0] && !wr_en[0], "R11 enable next cycle", {rd_en[0], gnt[0], wr_en[0]}, 3'b110);
    check(a_addr[0] == 16'h0A10 && a_size[0] == 2'd3, "R6 address driven", a_addr[0], 16'h0A10);
    while (!done[0]) @(negedge clk);
    @(posedge clk);
    #1 req_v[0] = 1'b0;
    repeat (2) @(posedge clk);

    // R2: mode 00 same class, with R8 loser held off
    mode = 2'b00;
    @(posedge clk);
    #1;
    expect_item(0, 2'b01, 0, 16'h0100, 2'd1, 32'h0000_1111);
    expect_item(1, 2'b01, 0, 16'h0200, 2'd2, 32'h0000_2222);
    fork
      access(0, 2'b01, 0, 16'h0100, 2'd1, 32'h0000_1111);
      access(1, 2'b01, 0, 16'h0200, 2'd2, 32'h0000_2222);
      begin
        @(negedge clk);
        @(negedge clk);
        check(gnt == 2'b01, "R8 loser waits without grant", gnt, 2'b01);
      end
    join
    repeat (2) @(posedge clk);

    // R3: mode 01 same class
    mode = 2'b01;
    pair(1, 2'b10, 0, 16'h0300, 2'b10, 0, 16'h0400);
    // R1: read beats prefetch under mode 00 (port 1 wins)
    mode = 2'b00;
    pair(1, 2'b00, 1, 16'h0500, 2'b01, 1, 16'h0600);
    // R1: write beats read under mode 01 (port 0 wins)
    mode = 2'b01;
    pair(0, 2'b10, 0, 16'h0700, 2'b01, 0, 16'h0800);
    // R1: read beats prefetch under mode 01 (port 0 wins)
    pair(0, 2'b01, 1, 16'h0900, 2'b00, 1, 16'h0A00);

    // R5: different arrays proceed together
    mode = 2'b00;
    pair(0, 2'b01, 0, 16'h0B00, 2'b10, 1, 16'h0C00);
    check(done_cyc[0] == done_cyc[1], "R5 concurrent completion", done_cyc[1], done_cyc[0]);

    // R4: alternating mode on array 1
    mode = 2'b10;
    pair(0, 2'b01, 1, 16'h1000, 2'b01, 1, 16'h1100);
    pair(1, 2'b01, 1, 16'h1200, 2'b01, 1, 16'h1300);
    pair(0, 2'b10, 1, 16'h1400, 2'b01, 1, 16'h1500); // class-decided, favour unchanged
    mode = 2'b11;
    pair(0, 2'b00, 1, 16'h1600, 2'b00, 1, 16'h1700);
    pair(1, 2'b10, 1, 16'h1800, 2'b11, 1, 16'h1900);
    // R4: array 0 keeps its own favour (still port 0)
    pair(0, 2'b01, 0, 16'h1A00, 2'b01, 0, 16'h1B00);

    // R10: stray completion on idle array is ignored
    @(posedge clk);
    #1 stray[1] = 1'b1;
    @(negedge clk);
    check(done == 2'b00, "R10 stray ack gives no done", done, 0);
    @(posedge clk);
    #1 stray[1] = 1'b0;
    @(negedge clk);
    check({rd_en[1], wr_en[1], gnt} == '0, "R10 stray ack starts nothing", {rd_en[1], wr_en[1], gnt}, 0);
    pair(1, 2'b00, 1, 16'h1C00, 2'b10, 1, 16'h1D00);

    repeat (4) @(posedge clk);
    check(exp_q.size() == 0, "R7 all completions returned", exp_q.size(), 0);
    check(mon_fail == 0, "R8 idle gap and R7 quiet data", mon_fail, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule